// File: doc/BRIEF.md
# Memory dependence wakeup tracker

This block decides when each in-flight memory operation of an out-of-order core may issue. Loads, stores and the two kinds of ordering barrier are written into a small fully associative table keyed by their sequence number. On entry, a load or store is made to wait on a producer. That producer is the youngest pending barrier that covers the operation's kind. When no such barrier is pending, the producer is the one named by an external dependence predictor. Operations that find no live producer are memory-ready at once.

An operation is handed to the issue logic only when it holds two readiness bits: one for its source registers and one for memory ordering. When a producer completes, its sequence number is broadcast as a tag, and every entry waiting on that tag becomes memory-ready. Non-speculative accesses bypass the dependence check and leave only when told to. Operations that have to be re-executed are parked in a queue and all leave together in arrival order when a replay is requested.

All requests share one command port, one command per cycle. Releases leave through a valid/ready port, one per cycle.

Top module: `mdw_tracker`

## Requirements
- R1: An insert (op 0) of a load (kind 0) or store (kind 1) with producer 0 and registers ready is offered on the release port in the next cycle. With registers not ready, it is offered only after a register-ready command (op 1) for its sequence number.
- R2: A nonzero predicted producer whose sequence number is not held in the table counts as no dependence.
- R3: An operation whose producer is held in the table is not released by a register-ready command alone. It is released once the producer completes (op 5) and its registers are ready.
- R4: A full barrier (kind 2) makes later loads and stores wait on it. Its completion wakes all of them in the same cycle, and they leave lowest table slot first (a slot being the lowest free one at insert).
- R5: A write barrier (kind 3) makes later stores wait but not later loads.
- R6: A pending barrier that covers the operation's kind takes the place of the predicted producer. Completing the predicted producer then releases nothing.
- R7: Completing a barrier clears the pending barrier only if it is the most recent one of that kind. A newer pending barrier stays in force.
- R8: A non-speculative insert (nonspec flag set) is never released by readiness. It leaves only on a non-speculative-ready command (op 2).
- R9: A reschedule command (op 3) parks an entry. A replay command (op 4) releases all parked entries, one per cycle, in the order they were parked.
- R10: A release that is not accepted keeps the same sequence number on the release port while no new command arrives.
- R11: With every slot in use, ins_ready is low. An insert is then dropped and err is raised in the next cycle.
- R12: A register-ready, non-speculative-ready, reschedule or complete command naming a sequence number not in the table raises err for exactly the next cycle.
- R13: The four counters hold the number of accepted loads, accepted stores, loads that had to wait and stores that had to wait. Non-speculative accesses count by their kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 insert, 1 register-ready, 2 non-speculative-ready, 3 reschedule, 4 replay, 5 complete |
| cmd_seq | input | SEQ_W | Sequence number the command names |
| cmd_kind | input | 2 | Insert kind: 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_nonspec | input | 1 | Insert is a non-speculative access |
| cmd_pred | input | SEQ_W | Producer named by the predictor, 0 for none |
| cmd_regs | input | 1 | Source registers ready at insert |
| ins_ready | output | 1 | A free slot exists |
| rel_valid | output | 1 | A released operation is offered |
| rel_ready | input | 1 | Issue logic accepts the offered operation |
| rel_seq | output | SEQ_W | Sequence number of the offered operation |
| err | output | 1 | Previous command was dropped or named an absent entry |
| n_loads | output | CNT_W | Accepted loads |
| n_stores | output | CNT_W | Accepted stores |
| n_ld_wait | output | CNT_W | Loads that had to wait |
| n_st_wait | output | CNT_W | Stores that had to wait |

## Verification
A wrong readiness bit or a lost producer tag shows up in one of two ways. Either an operation appears on the release port one cycle after an insert or event that should have held it, or it never appears, and the scoreboard then reports a missing item a few cycles later. A stale pending-barrier register shows on the very next insert of the covered kind, as a release that should not have happened or one that does not come. Errors in table allocation or search show up as ins_ready or err being wrong in the cycle right after the command.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

    typedef enum logic [2:0] {
        OP_INSERT   = 3'd0,
        OP_REGRDY   = 3'd1,
        OP_NSRDY    = 3'd2,
        OP_RESCHED  = 3'd3,
        OP_REPLAY   = 3'd4,
        OP_COMPLETE = 3'd5
    } mdw_op_e;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_FULLBAR = 2'd2,
        K_WRBAR   = 2'd3
    } mdw_kind_e;

    // Per-slot state bits; sequence number and wait tag are kept apart
    typedef struct packed {
        logic      vld;
        logic      mem_rdy;
        logic      reg_rdy;
        logic      fire;
        logic      waiting;
        logic      nonspec;
        mdw_kind_e kind;
    } mdw_slot_t;

    function automatic logic is_barrier(mdw_kind_e k);
        return (k == K_FULLBAR) || (k == K_WRBAR);
    endfunction

endpackage

// File: rtl/mdw_pick.sv
module mdw_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mdw_fifo.sv
module mdw_fifo #(
    parameter int W     = 3,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          full, do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/mdw_tracker.sv
module mdw_tracker
    import mdw_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_nonspec,
    input  logic [SEQ_W-1:0] cmd_pred,
    input  logic             cmd_regs,
    output logic             ins_ready,
    output logic             rel_valid,
    input  logic             rel_ready,
    output logic [SEQ_W-1:0] rel_seq,
    output logic             err,
    output logic [CNT_W-1:0] n_loads,
    output logic [CNT_W-1:0] n_stores,
    output logic [CNT_W-1:0] n_ld_wait,
    output logic [CNT_W-1:0] n_st_wait
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mdw_slot_t        slot   [DEPTH];
    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [SEQ_W-1:0] wtag_q [DEPTH];

    logic             ldb_q, stb_q, drain_q;
    logic [SEQ_W-1:0] ldb_sn, stb_sn;

    mdw_op_e          op;
    mdw_kind_e        kind;
    logic [SEQ_W-1:0] prod;
    logic [DEPTH-1:0] cmd_hit, prod_hit, free_v, fire_v;
    logic             hit_any, free_any, fire_any;
    logic [IDX_W-1:0] hit_idx, free_idx, fire_idx, fq_dout;
    logic             fq_empty, use_fifo, take;
    logic             ins_ok, plain_op, dep_found, wait_now, miss, is_evt;
    mdw_slot_t        new_slot;

    assign op   = mdw_op_e'(cmd_op);
    assign kind = mdw_kind_e'(cmd_kind);

    // A pending barrier of the matching kind overrides the predictor
    always_comb begin
        if (kind == K_LOAD && ldb_q)       prod = ldb_sn;
        else if (kind == K_STORE && stb_q) prod = stb_sn;
        else                               prod = cmd_pred;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign cmd_hit[g]  = slot[g].vld && (seq_q[g] == cmd_seq);
        assign prod_hit[g] = slot[g].vld && (seq_q[g] == prod);
        assign free_v[g]   = !slot[g].vld;
        assign fire_v[g]   = slot[g].fire;
    end

    mdw_pick #(.N(DEPTH), .IW(IDX_W)) u_pick_hit  (.req(cmd_hit), .any(hit_any),  .idx(hit_idx));
    mdw_pick #(.N(DEPTH), .IW(IDX_W)) u_pick_free (.req(free_v),  .any(free_any), .idx(free_idx));
    mdw_pick #(.N(DEPTH), .IW(IDX_W)) u_pick_fire (.req(fire_v),  .any(fire_any), .idx(fire_idx));

    mdw_fifo #(.W(IDX_W), .DEPTH(DEPTH)) u_replay (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_valid && op == OP_RESCHED && hit_any),
        .din   (hit_idx),
        .pop   (take && use_fifo),
        .dout  (fq_dout),
        .empty (fq_empty)
    );

    assign ins_ready = free_any;
    assign use_fifo  = drain_q && !fq_empty;
    assign rel_valid = use_fifo || fire_any;
    assign rel_seq   = use_fifo ? seq_q[fq_dout] : seq_q[fire_idx];
    assign take      = rel_valid && rel_ready;

    assign ins_ok    = cmd_valid && op == OP_INSERT && free_any;
    assign plain_op  = !cmd_nonspec && !is_barrier(kind);
    assign dep_found = (prod != '0) && (|prod_hit);
    assign wait_now  = plain_op && dep_found;
    assign is_evt    = cmd_valid && (op == OP_REGRDY || op == OP_NSRDY ||
                                     op == OP_RESCHED || op == OP_COMPLETE);
    assign miss      = (is_evt && !hit_any) || (cmd_valid && op == OP_INSERT && !free_any);

    always_comb begin
        new_slot         = '0;
        new_slot.vld     = 1'b1;
        new_slot.mem_rdy = plain_op && !dep_found;
        new_slot.reg_rdy = cmd_regs;
        new_slot.fire    = plain_op && !dep_found && cmd_regs;
        new_slot.waiting = wait_now;
        new_slot.nonspec = cmd_nonspec;
        new_slot.kind    = kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i]   <= '0;
                seq_q[i]  <= '0;
                wtag_q[i] <= '0;
            end
            ldb_q     <= 1'b0;
            stb_q     <= 1'b0;
            ldb_sn    <= '0;
            stb_sn    <= '0;
            drain_q   <= 1'b0;
            err       <= 1'b0;
            n_loads   <= '0;
            n_stores  <= '0;
            n_ld_wait <= '0;
            n_st_wait <= '0;
        end else begin
            err <= miss;
            if (take && !use_fifo) slot[fire_idx].fire <= 1'b0;

            if (cmd_valid && op == OP_REPLAY) drain_q <= 1'b1;
            else if (fq_empty)                drain_q <= 1'b0;

            if (ins_ok) begin
                slot[free_idx]   <= new_slot;
                seq_q[free_idx]  <= cmd_seq;
                wtag_q[free_idx] <= prod;
                if (kind == K_FULLBAR) begin
                    ldb_q  <= 1'b1;
                    ldb_sn <= cmd_seq;
                end
                if (is_barrier(kind)) begin
                    stb_q  <= 1'b1;
                    stb_sn <= cmd_seq;
                end
                if (kind == K_LOAD) begin
                    n_loads <= n_loads + CNT_W'(1);
                    if (wait_now) n_ld_wait <= n_ld_wait + CNT_W'(1);
                end
                if (kind == K_STORE) begin
                    n_stores <= n_stores + CNT_W'(1);
                    if (wait_now) n_st_wait <= n_st_wait + CNT_W'(1);
                end
            end else if (is_evt && hit_any) begin
                case (op)
                    OP_REGRDY: begin
                        slot[hit_idx].reg_rdy <= 1'b1;
                        if (slot[hit_idx].mem_rdy) slot[hit_idx].fire <= 1'b1;
                    end
                    OP_NSRDY: slot[hit_idx].fire <= 1'b1;
                    OP_COMPLETE: begin
                        // Broadcast the finished tag to every waiter
                        for (int i = 0; i < DEPTH; i++) begin
                            if (slot[i].vld && slot[i].waiting && wtag_q[i] == cmd_seq) begin
                                slot[i].waiting <= 1'b0;
                                slot[i].mem_rdy <= 1'b1;
                                if (slot[i].reg_rdy) slot[i].fire <= 1'b1;
                            end
                        end
                        slot[hit_idx] <= '0;
                        if (ldb_q && ldb_sn == cmd_seq) ldb_q <= 1'b0;
                        if (stb_q && stb_sn == cmd_seq) stb_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdw_tracker_chk.sv
module mdw_tracker_chk #(
    parameter int SEQ_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [1:0]       cmd_kind,
    input logic             ins_ready,
    input logic             rel_valid,
    input logic             rel_ready,
    input logic [SEQ_W-1:0] rel_seq,
    input logic             err,
    input logic [CNT_W-1:0] n_loads,
    input logic [CNT_W-1:0] n_ld_wait
);
    // R10
    rel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rel_valid && !rel_ready && !cmd_valid |=> rel_valid && $stable(rel_seq));

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 3'd0 && !ins_ready |=> err);

    // R12
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(cmd_valid));

    // R13
    load_count_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 3'd0 && ins_ready && cmd_kind == 2'd0
        |=> n_loads == CNT_W'($past(n_loads) + CNT_W'(1)));

    // R13
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        n_ld_wait <= n_loads);
endmodule

bind mdw_tracker mdw_tracker_chk #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_kind  (cmd_kind),
    .ins_ready (ins_ready),
    .rel_valid (rel_valid),
    .rel_ready (rel_ready),
    .rel_seq   (rel_seq),
    .err       (err),
    .n_loads   (n_loads),
    .n_ld_wait (n_ld_wait)
);

// File: tb/mdw_tracker_test.sv
module mdw_tracker_test;
    localparam int SW = 8;
    localparam int D  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [SW-1:0] cmd_seq = '0;
    logic [1:0]    cmd_kind = '0;
    logic          cmd_nonspec = 1'b0;
    logic [SW-1:0] cmd_pred = '0;
    logic          cmd_regs = 1'b0;
    logic          rel_ready = 1'b1;
    logic          ins_ready, rel_valid, err;
    logic [SW-1:0] rel_seq;
    logic [CW-1:0] n_loads, n_stores, n_ld_wait, n_st_wait;

    mdw_tracker #(.SEQ_W(SW), .DEPTH(D), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_seq(cmd_seq), .cmd_kind(cmd_kind), .cmd_nonspec(cmd_nonspec),
        .cmd_pred(cmd_pred), .cmd_regs(cmd_regs), .ins_ready(ins_ready),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_seq(rel_seq),
        .err(err), .n_loads(n_loads), .n_stores(n_stores),
        .n_ld_wait(n_ld_wait), .n_st_wait(n_st_wait)
    );

    always #4 clk = ~clk;

    int            checks = 0;
    int            fails = 0;
    bit            finished = 0;
    string         cur_req = "R1";
    logic [SW-1:0] expq[$];
    int            e_ld = 0, e_st = 0, e_ldw = 0, e_stw = 0;

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // Scoreboard monitor: every accepted release must match the queue head
    always @(negedge clk) begin
        #1;
        if (!rst && rel_valid && rel_ready) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL %s actual=%0d expected=none", cur_req, rel_seq);
            end else begin
                logic [SW-1:0] e;
                e = expq.pop_front();
                if (rel_seq !== e) begin
                    fails++;
                    $display("FAIL %s actual=%0d expected=%0d", cur_req, rel_seq, e);
                end
            end
        end
    end

    task automatic send(int op, int seq, int kind = 0, int pred = 0, int regs = 0, int ns = 0);
        cmd_valid   = 1'b1;
        cmd_op      = 3'(op);
        cmd_seq     = SW'(seq);
        cmd_kind    = 2'(kind);
        cmd_pred    = SW'(pred);
        cmd_regs    = regs[0];
        cmd_nonspec = ns[0];
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic ins(int seq, int kind, int pred, int regs, int w = 0, int ns = 0);
        if (kind == 0) begin e_ld++; if (w != 0) e_ldw++; end
        if (kind == 1) begin e_st++; if (w != 0) e_stw++; end
        send(0, seq, kind, pred, regs, ns);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(string r);
        idle(4);
        chk(r, expq.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset rel_valid", int'(rel_valid), 0);
        chk("R11 reset ins_ready", int'(ins_ready), 1);
        chk("R12 reset err", int'(err), 0);
        chk("R13 reset n_loads", int'(n_loads), 0);

        cur_req = "R1";
        expq.push_back(1); ins(1, 0, 0, 1);
        drained("R1 immediate"); send(5, 1);
        ins(2, 0, 0, 0); idle(3); chk("R1 held without regs", expq.size(), 0);
        expq.push_back(2); send(1, 2); drained("R1 after reg-ready"); send(5, 2);

        cur_req = "R2";
        expq.push_back(5); ins(5, 0, 99, 1); drained("R2 absent producer"); send(5, 5);

        cur_req = "R3";
        expq.push_back(3); ins(3, 1, 0, 1); drained("R3 producer store");
        ins(4, 0, 3, 1, 1); idle(3); chk("R3 dependent waits", expq.size(), 0);
        expq.push_back(4); send(5, 3); drained("R3 wake on complete"); send(5, 4);
        expq.push_back(6); ins(6, 1, 0, 1); drained("R3 second producer");
        ins(7, 0, 6, 0, 1); send(1, 7); idle(3);
        chk("R3 reg-ready alone holds", expq.size(), 0);
        expq.push_back(7); send(5, 6); drained("R3 both bits"); send(5, 7);

        cur_req = "R4";
        ins(10, 2, 0, 0); ins(11, 0, 0, 1, 1); ins(12, 1, 0, 1, 1); idle(3);
        chk("R4 barrier blocks", expq.size(), 0);
        expq.push_back(11); expq.push_back(12); send(5, 10);
        drained("R4 wake order"); send(5, 11); send(5, 12);
        expq.push_back(13); ins(13, 0, 0, 1); drained("R4 barrier cleared"); send(5, 13);

        cur_req = "R5";
        ins(20, 3, 0, 0); expq.push_back(21); ins(21, 0, 0, 1);
        ins(22, 1, 0, 1, 1); drained("R5 load passes store waits");
        expq.push_back(22); send(5, 20); drained("R5 store woken");
        send(5, 21); send(5, 22);

        cur_req = "R7";
        ins(30, 3, 0, 0); ins(31, 3, 0, 0); send(5, 30);
        ins(32, 1, 0, 1, 1); idle(3); chk("R7 newer barrier holds", expq.size(), 0);
        expq.push_back(32); send(5, 31); drained("R7 newer completes"); send(5, 32);

        cur_req = "R6";
        expq.push_back(41); ins(41, 1, 0, 1); drained("R6 producer store");
        ins(42, 2, 0, 0); ins(43, 0, 41, 1, 1); send(5, 41); idle(3);
        chk("R6 predictor overridden", expq.size(), 0);
        expq.push_back(43); send(5, 42); drained("R6 barrier wake"); send(5, 43);

        cur_req = "R8";
        ins(50, 0, 0, 1, 0, 1); idle(3); chk("R8 nonspec held", expq.size(), 0);
        expq.push_back(50); send(2, 50); drained("R8 nonspec ready"); send(5, 50);

        cur_req = "R9";
        expq.push_back(60); ins(60, 0, 0, 1);
        expq.push_back(61); ins(61, 0, 0, 1);
        expq.push_back(62); ins(62, 0, 0, 1); drained("R9 first issue");
        send(3, 62); send(3, 60); send(3, 61); idle(3);
        chk("R9 parked", expq.size(), 0);
        expq.push_back(62); expq.push_back(60); expq.push_back(61);
        send(4, 0); drained("R9 replay order");
        send(5, 60); send(5, 61); send(5, 62);

        cur_req = "R10";
        rel_ready = 1'b0;
        expq.push_back(90); ins(90, 0, 0, 1);
        chk("R10 offered", int'(rel_valid), 1);
        chk("R10 seq", int'(rel_seq), 90);
        idle(3);
        chk("R10 still offered", int'(rel_valid), 1);
        chk("R10 seq stable", int'(rel_seq), 90);
        rel_ready = 1'b1; drained("R10 accepted"); send(5, 90);

        cur_req = "R12";
        send(1, 77); chk("R12 err pulse", int'(err), 1);
        idle(1); chk("R12 err clears", int'(err), 0);
        send(5, 78); chk("R12 err on absent complete", int'(err), 1);

        cur_req = "R11";
        for (int i = 0; i < D; i++) ins(100 + i, 0, 0, 0);
        chk("R11 full ins_ready", int'(ins_ready), 0);
        send(0, 108, 0, 0, 1); chk("R11 drop err", int'(err), 1);
        send(1, 108); chk("R11 dropped entry absent", int'(err), 1);
        idle(3); chk("R11 nothing released", expq.size(), 0);
        for (int i = 0; i < D; i++) send(5, 100 + i);
        chk("R11 space again", int'(ins_ready), 1);

        cur_req = "R13";
        chk("R13 loads", int'(n_loads), e_ld);
        chk("R13 stores", int'(n_stores), e_st);
        chk("R13 load waits", int'(n_ld_wait), e_ldw);
        chk("R13 store waits", int'(n_st_wait), e_stw);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule